// File: doc/BRIEF.md
# Latching Round-Robin ADC Trigger Arbiter

This block collects conversion requests for an ADC from four request lines and hands them to the converter one at a time. Two trigger-generating sources each drive a set of four request lines, and a source-select input decides which set is observed. A rising edge on an observed line is captured in a per-line latch. Requests that arrive together are all kept.

When the arbiter is idle and at least one latch is set, it issues a one-cycle trigger pulse together with the index of the line being served. It holds that index steady until the ADC reports completion. Service rotates: the search for the next request begins just after the line served last and wraps around.

Software-visible status is a per-line latch field, which is non-zero while anything is pending or in service, and a per-line error field with write-1-to-clear behaviour. A repeated edge on a line that is already pending or in service sets that line's error bit. A flush input empties the queue but leaves the conversion in progress alone.

The interface carries no data stream, so there is no valid/ready pair. The trigger pulse cannot be held back. The ADC completion pulse is the only handshake, and it paces the issue of further pulses. The source select may only change while the latch field reads zero and both sources are quiet.

Top module: `adc_trig_rr_latch`

## Requirements
- R1: After reset the latch field, the error field and the trigger pulse are all zero, and the first search starts at line 0, so four simultaneous requests are served in the order 0, 1, 2, 3.
- R2: Only the lines of the selected source are observed: `src_sel`=0 selects `src_a_req` and `src_sel`=1 selects `src_b_req`. Edges on the other source have no effect.
- R3: A rising edge on an observed line, sampled at a clock edge, sets bit i of `latch_status` from that edge onward. Edges on several lines in one cycle set every one of those bits.
- R4: When the arbiter is idle, not flushing, and has a pending line, the next clock edge starts service. `trig_pulse` goes high for exactly one cycle, and `trig_idx` shows the served line and stays unchanged until a new service starts.
- R5: No new trigger pulse is issued while a line is in service. Service ends at the clock edge that samples `conv_done` high. `conv_done` while idle is ignored.
- R6: After line P has been served, the next winner is the first pending line in the order P+1, P+2, … , N-1, 0, … , P.
- R7: A rising edge on a line that is already pending or in service is dropped and sets bit i of `err_flags`.
- R8: With `err_clr_we` high, each `err_flags` bit whose `err_clr_mask` bit is 1 is cleared; bits written 0 keep their value. A new error in the same cycle wins over a clear.
- R9: `latch_status` is the OR of the pending bits and a one-hot bit for the line in service, so it reads all zeros only when nothing is pending and no conversion is in service.
- R10: A cycle with `flush` high clears every pending bit, drops edges sampled in that cycle without error, and starts no new service. A line in service stays in service with its index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 1 | Source choice: 0 selects source A, 1 selects source B |
| src_a_req | input | N | Request lines of source A |
| src_b_req | input | N | Request lines of source B |
| conv_done | input | 1 | ADC completion pulse for the line in service |
| flush | input | 1 | Drop all pending requests, keep the one in service |
| err_clr_we | input | 1 | Write strobe for the error clear mask |
| err_clr_mask | input | N | Write-1-to-clear mask for `err_flags` |
| trig_pulse | output | 1 | One-cycle conversion trigger |
| trig_idx | output | log2(N) | Line being served, held during service |
| latch_status | output | N | Pending or in-service indication per line |
| err_flags | output | N | Sticky per-line repeat-request error |

## Verification
A wrong pending bit shows at once in `latch_status`, one edge after the request. A wrong rotation pointer stays hidden until two or more lines compete, and then shows as a wrong `trig_idx` on the next pulse. A busy flag that clears too early or too late shows as an extra pulse, or a missing one, within a cycle of `conv_done`, and also as the wrong dropped-or-latched outcome for a repeat edge, which `err_flags` exposes. For this reason the outputs are compared against a reference model on every clock, and the directed cases force contention, repeats during service, and a flush with work both queued and in service.

// File: rtl/trg_arb_pkg.sv
package trg_arb_pkg;
  // default number of request lines handled by the arbiter
  localparam int unsigned TRG_LINES = 4;
endpackage

// File: rtl/trg_edge_capture.sv
module trg_edge_capture #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic [N-1:0] lines_a,
  input  logic [N-1:0] lines_b,
  output logic [N-1:0] rise
);
  logic [N-1:0] chosen;
  logic [N-1:0] prev_q;

  assign chosen = sel ? lines_b : lines_a;
  assign rise   = chosen & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= chosen;
  end

  // R3: an edge is only reported on a line that was low on the previous cycle
  p_edge_from_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise & $past(chosen)) == '0));
endmodule

// File: rtl/trg_rr_pick.sv
module trg_rr_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  pending,
  input  logic [IW-1:0] start,
  output logic          found,
  output logic [IW-1:0] winner
);
  always_comb begin
    found  = 1'b0;
    winner = '0;
    for (int off = 0; off < int'(N); off++) begin
      int k;
      k = (int'(start) + off) % int'(N);
      if (!found && pending[k]) begin
        found  = 1'b1;
        winner = IW'(k);
      end
    end
  end

  // R6: the chosen line is always one that is actually pending
  always_comb begin
    if (found) a_winner_pending_r6: assert (pending[winner]);
  end
endmodule

// File: rtl/trg_err_flags.sv
module trg_err_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flags
);
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_eff) | set;
  end

  // R8: with no clear strobe, no error bit ever falls
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/adc_trig_rr_latch.sv
module adc_trig_rr_latch
  import trg_arb_pkg::*;
#(
  parameter int unsigned N = TRG_LINES,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_sel,
  input  logic [N-1:0]  src_a_req,
  input  logic [N-1:0]  src_b_req,
  input  logic          conv_done,
  input  logic          flush,
  input  logic          err_clr_we,
  input  logic [N-1:0]  err_clr_mask,
  output logic          trig_pulse,
  output logic [IW-1:0] trig_idx,
  output logic [N-1:0]  latch_status,
  output logic [N-1:0]  err_flags
);
  logic [N-1:0]  rise;
  logic [N-1:0]  pend_q;
  logic          busy_q;
  logic [IW-1:0] cur_q;
  logic [IW-1:0] start_q;
  logic          pulse_q;
  logic          found;
  logic [IW-1:0] win;
  logic [N-1:0]  inserv;
  logic [N-1:0]  conflict;
  logic [N-1:0]  accept;
  logic [N-1:0]  err_set;
  logic          grant;
  logic [N-1:0]  grant_mask;

  trg_edge_capture #(.N(N)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (src_sel),
    .lines_a (src_a_req),
    .lines_b (src_b_req),
    .rise    (rise)
  );

  trg_rr_pick #(.N(N), .IW(IW)) u_pick (
    .pending (pend_q),
    .start   (start_q),
    .found   (found),
    .winner  (win)
  );

  assign inserv     = busy_q ? (N'(1) << cur_q) : '0;
  assign conflict   = rise & (pend_q | inserv);
  assign accept     = flush ? '0 : (rise & ~conflict);
  assign err_set    = flush ? '0 : conflict;
  assign grant      = !busy_q && !flush && found;
  assign grant_mask = grant ? (N'(1) << win) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      busy_q  <= 1'b0;
      cur_q   <= '0;
      start_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (flush) pend_q <= '0;
      else       pend_q <= (pend_q & ~grant_mask) | accept;
      pulse_q <= grant;
      if (grant) begin
        busy_q  <= 1'b1;
        cur_q   <= win;
        start_q <= (win == IW'(N - 1)) ? '0 : IW'(win + 1'b1);
      end else if (busy_q && conv_done) begin
        busy_q <= 1'b0;
      end
    end
  end

  trg_err_flags #(.N(N)) u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (err_set),
    .clr_we   (err_clr_we),
    .clr_mask (err_clr_mask),
    .flags    (err_flags)
  );

  assign trig_pulse   = pulse_q;
  assign trig_idx     = cur_q;
  assign latch_status = pend_q | inserv;

  // R4: a trigger lasts exactly one cycle
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);
  // R4: the served index does not move during a conversion
  p_idx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !trig_pulse) |-> $stable(trig_idx));
  // R5: a trigger is only issued from the idle state
  p_pulse_from_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> !$past(busy_q));
  // R10: a flush empties the queue but keeps the conversion in service
  p_flush_spares_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && busy_q && !conv_done) |=> (pend_q == '0) && busy_q && $stable(cur_q));
endmodule

// File: tb/adc_trig_rr_latch_tb_top.sv
module adc_trig_rr_latch_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_sel = 1'b0;
  logic [3:0] src_a_req = '0;
  logic [3:0] src_b_req = '0;
  logic       man_done = 1'b0;
  logic       auto_pulse = 1'b0;
  logic       conv_done_w;
  logic       flush = 1'b0;
  logic       err_clr_we = 1'b0;
  logic [3:0] err_clr_mask = '0;
  logic       trig_pulse;
  logic [1:0] trig_idx;
  logic [3:0] latch_status;
  logic [3:0] err_flags;

  int n_cmp = 0;
  int n_bad = 0;
  int served_q[$];
  logic auto_done = 1'b1;
  int   dly = 0;

  assign conv_done_w = auto_pulse | man_done;

  always #2 clk = ~clk;

  adc_trig_rr_latch dut_i (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
    .src_a_req(src_a_req), .src_b_req(src_b_req),
    .conv_done(conv_done_w), .flush(flush),
    .err_clr_we(err_clr_we), .err_clr_mask(err_clr_mask),
    .trig_pulse(trig_pulse), .trig_idx(trig_idx),
    .latch_status(latch_status), .err_flags(err_flags)
  );

  // behavioural reference model, updated at each rising edge
  logic [3:0] m_pend, m_err, m_prev, m_s, m_p0;
  logic       m_busy, m_pulse, m_b0;
  int         m_cur, m_start, m_c0, m_w;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_err = '0; m_prev = '0;
      m_busy = 1'b0; m_pulse = 1'b0; m_cur = 0; m_start = 0;
    end else begin
      m_s  = src_sel ? src_b_req : src_a_req;
      m_p0 = m_pend; m_b0 = m_busy; m_c0 = m_cur;
      m_w  = -1;
      if (!m_b0 && !flush)
        for (int k = 0; k < 4; k++) begin
          int j;
          j = (m_start + k) % 4;
          if (m_w < 0 && m_p0[j]) m_w = j;
        end
      if (err_clr_we) m_err = m_err & ~err_clr_mask;
      for (int i = 0; i < 4; i++)
        if (m_s[i] && !m_prev[i] && !flush) begin
          if (m_p0[i] || (m_b0 && m_c0 == i)) m_err[i] = 1'b1;
          else m_pend[i] = 1'b1;
        end
      if (flush) m_pend = '0;
      if (m_b0 && conv_done_w) m_busy = 1'b0;
      m_pulse = 1'b0;
      if (m_w >= 0) begin
        m_pend[m_w] = 1'b0; m_busy = 1'b1; m_cur = m_w;
        m_start = (m_w + 1) % 4; m_pulse = 1'b1;
      end
      m_prev = m_s;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] exp_ls;
      exp_ls = m_pend | (m_busy ? (4'b0001 << m_cur) : 4'b0000);
      n_cmp++;
      if (trig_pulse !== m_pulse || (m_pulse && trig_idx !== 2'(m_cur))) begin
        n_bad++;
        $display("FAIL R4 trigger: pulse=%0b idx=%0d expected pulse=%0b idx=%0d",
                 trig_pulse, trig_idx, m_pulse, m_cur);
      end
      n_cmp++;
      if (latch_status !== exp_ls) begin
        n_bad++;
        $display("FAIL R9 latch_status: got %b expected %b", latch_status, exp_ls);
      end
      n_cmp++;
      if (err_flags !== m_err) begin
        n_bad++;
        $display("FAIL R7 err_flags: got %b expected %b", err_flags, m_err);
      end
      if (trig_pulse) served_q.push_back(int'(trig_idx));
    end
  end

  // ADC stand-in: completes three cycles after each trigger when enabled
  always @(negedge clk) begin
    auto_pulse = 1'b0;
    if (!rst_n) dly = 0;
    else if (trig_pulse && auto_done) dly = 3;
    else if (dly > 0) begin
      dly--;
      if (dly == 0) auto_pulse = 1'b1;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    int lim;
    lim = 0;
    tick(1);
    while (latch_status != 0 && lim < 200) begin tick(1); lim++; end
    tick(2);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int base;
    tick(3);
    // R1: reset state
    chk("R1 latch after reset", int'(latch_status), 0);
    chk("R1 err after reset", int'(err_flags), 0);
    chk("R1 pulse after reset", int'(trig_pulse), 0);
    rst_n = 1'b1;
    tick(2);

    // R3 / R1 / R6: four simultaneous requests
    src_a_req = 4'b1111; tick(1);
    src_a_req = 4'b0000; tick(1);
    chk("R3 all four latched", int'(latch_status), 15);
    wait_idle();
    chk("R1 served count", served_q.size(), 4);
    for (int i = 0; i < 4; i++) chk("R1 order from line 0", served_q[i], i);

    // R6: rotation continues after the last served line
    served_q.delete();
    src_a_req = 4'b0010; tick(1); src_a_req = 4'b0000;
    wait_idle();
    src_a_req = 4'b1001; tick(1); src_a_req = 4'b0000;
    wait_idle();
    chk("R6 served count", served_q.size(), 3);
    if (served_q.size() == 3) begin
      chk("R6 first", served_q[0], 1);
      chk("R6 rotated to line 3", served_q[1], 3);
      chk("R6 wrapped to line 0", served_q[2], 0);
    end

    // R7: repeat edge while the line is in service
    served_q.delete();
    src_a_req = 4'b0100; tick(1);
    src_a_req = 4'b0000; tick(1);
    src_a_req = 4'b0100; tick(1);
    src_a_req = 4'b0000;
    wait_idle();
    chk("R7 error bit set", int'(err_flags), 4);
    chk("R7 single service", served_q.size(), 1);

    // R8: write-1-to-clear
    err_clr_we = 1'b1; err_clr_mask = 4'b1011; tick(1);
    err_clr_we = 1'b0; err_clr_mask = 4'b0000; tick(1);
    chk("R8 zero mask bit keeps error", int'(err_flags), 4);
    err_clr_we = 1'b1; err_clr_mask = 4'b0100; tick(1);
    err_clr_we = 1'b0; err_clr_mask = 4'b0000; tick(1);
    chk("R8 error cleared", int'(err_flags), 0);

    // R10: flush spares the conversion in service
    auto_done = 1'b0;
    served_q.delete();
    src_a_req = 4'b0001; tick(1); src_a_req = 4'b0000; tick(3);
    src_a_req = 4'b0110; tick(1); src_a_req = 4'b0000; tick(1);
    chk("R10 queue before flush", int'(latch_status), 7);
    flush = 1'b1; tick(1); flush = 1'b0; tick(1);
    chk("R10 only in-service remains", int'(latch_status), 1);
    chk("R10 in-service index", int'(trig_idx), 0);
    man_done = 1'b1; tick(1); man_done = 1'b0; tick(4);
    chk("R10 idle after completion", int'(latch_status), 0);
    chk("R10 flushed lines not served", served_q.size(), 1);

    // R5: completion while idle has no effect
    base = served_q.size();
    man_done = 1'b1; tick(1); man_done = 1'b0; tick(3);
    chk("R5 stray done no pulse", served_q.size(), base);
    chk("R5 stray done status", int'(latch_status), 0);
    // R5: no second pulse while waiting for completion
    src_a_req = 4'b1000; tick(1); src_a_req = 4'b0000; tick(3);
    src_a_req = 4'b0001; tick(1); src_a_req = 4'b0000; tick(5);
    chk("R5 held off while busy", served_q.size(), base + 1);
    man_done = 1'b1; tick(1); man_done = 1'b0; tick(3);
    chk("R5 next after done", served_q.size(), base + 2);
    man_done = 1'b1; tick(1); man_done = 1'b0;
    auto_done = 1'b1;
    wait_idle();

    // R2: unselected source ignored, then switch source while idle
    base = served_q.size();
    src_b_req = 4'b1000; tick(1); src_b_req = 4'b0000; tick(3);
    chk("R2 source B ignored", int'(latch_status), 0);
    src_sel = 1'b1; tick(2);
    src_a_req = 4'b0001; tick(1); src_a_req = 4'b0000; tick(3);
    chk("R2 source A ignored", served_q.size(), base);
    src_b_req = 4'b1000; tick(1); src_b_req = 4'b0000;
    wait_idle();
    chk("R2 source B served", served_q.size(), base + 1);
    if (served_q.size() == base + 1) chk("R2 source B line", served_q[base], 3);

    finish_run();
  end
endmodule